// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Fill Port

This block lets a bus master fill a 128 KiB work RAM through one memory-mapped data register. It watches the master's write strobe and address, and decodes four register slots. Three of the slots load a 17-bit RAM pointer one byte at a time: the low byte, the middle byte, and a top slot that supplies only the pointer's most significant bit. The fourth slot is the data port.

Each write to the data port turns into one write cycle on a synchronous 128K x 8 RAM, at the address the pointer held before that write. The pointer then moves on by one. A master can therefore stream a block of bytes into RAM with repeated writes to a single address, after it has set the start position once.

Only the low 16 bits of the bus address take part in decoding, so every bank reaches the same four slots. Reading back through the data port and sharing the RAM with other masters are not part of this block.

Top module: `wram_fill_port`

## Requirements
- R1: After reset the pointer is 0x00000 and `ram_we` is low. The first data-port write after reset goes to RAM address 0.
- R2: A write to offset 0x2180 drives `ram_we` high for exactly the following clock cycle. In that cycle `ram_addr` equals the pointer value from before the write and `ram_wdata` equals the written byte.
- R3: Each data-port write raises the pointer by one. Back-to-back data writes therefore land on consecutive RAM addresses.
- R4: A write to offset 0x2181 replaces pointer bits 7:0 with the data byte and leaves bits 16:8 unchanged.
- R5: A write to offset 0x2182 replaces pointer bits 15:8 with the data byte and leaves bits 16 and 7:0 unchanged.
- R6: A write to offset 0x2183 sets pointer bit 16 from data bit 0. Data bits 7:1 are ignored and pointer bits 15:0 are unchanged.
- R7: When the pointer holds 0x1FFFF, a data-port write wraps it to 0x00000.
- R8: Decoding looks only at bus address bits 15:0. The four slots respond the same way whatever bits 23:16 hold.
- R9: A write whose low 16 address bits match none of 0x2180 to 0x2183, or a cycle with `bus_wr` low, leaves the pointer unchanged and issues no RAM write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one write per cycle while high |
| bus_addr | input | 24 | Bus write address |
| bus_data | input | 8 | Bus write data |
| ram_we | output | 1 | RAM write enable, high for one cycle per data-port write |
| ram_addr | output | 17 | RAM write address |
| ram_wdata | output | 8 | RAM write data |

## Verification
The bench aims at the pointer edges. It loads 0x1FFFF and writes twice, so a pointer that saturated or carried into a lost 18th bit would send the second byte somewhere other than address 0. It writes the top slot with values whose bit 0 differs from their other bits; a design that took the wrong bit, or let the byte spill into bits 15:8, would then put later writes at the wrong addresses. Writes to the same slots with random upper address bits, and to addresses just outside the slot range, catch decoders that compare too many or too few bits. Long runs of back-to-back data writes catch an increment that is missing, doubled, or applied before the address is captured.

// File: rtl/wram_port_pkg.sv
// Shared definitions for the work-RAM fill port.
// Assumes the four register slots sit at consecutive offsets from a base.
package wram_port_pkg;

    // Register slot selected by the current bus cycle
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DATA = 3'd1,
        SEL_PLO  = 3'd2,
        SEL_PMID = 3'd3,
        SEL_PHI  = 3'd4
    } reg_sel_e;

    // Number of decoded slots (data, low, middle, top)
    localparam int unsigned NUM_SLOTS = 4;

endpackage

// File: rtl/wram_port_decode.sv
// Register decoder for the fill port.
// Compares only the low DEC_W address bits against BASE + slot index and
// yields one slot selection per cycle. Assumes at most one bus write per cycle.
module wram_port_decode
    import wram_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DEC_W  = 16,
    parameter logic [DEC_W-1:0] BASE = 16'h2180
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel
);

    logic [DEC_W-1:0]     low_addr;
    logic [NUM_SLOTS-1:0] hit;

    assign low_addr = bus_addr[DEC_W-1:0];

    // One comparator per slot at consecutive offsets from BASE
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [DEC_W-1:0] SLOT_ADDR = BASE + DEC_W'(g);
        assign hit[g] = bus_wr && (low_addr == SLOT_ADDR);
    end

    // Map the one-hot hit vector to a slot selection
    always_comb begin
        sel = SEL_NONE;
        unique case (hit)
            4'b0001: sel = SEL_DATA;
            4'b0010: sel = SEL_PLO;
            4'b0100: sel = SEL_PMID;
            4'b1000: sel = SEL_PHI;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/wram_port_ptr.sv
// RAM pointer register for the fill port.
// Holds a PTR_W-bit pointer that loads byte-wise (low, middle, top slice)
// and advances by one on each data-port write, wrapping modulo 2**PTR_W.
// Assumes 2*BYTE_W < PTR_W <= 3*BYTE_W.
module wram_port_ptr
    import wram_port_pkg::*;
#(
    parameter int unsigned PTR_W  = 17,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr
);

    localparam int unsigned TOP_W = PTR_W - 2 * BYTE_W;
    localparam int unsigned MID_L = BYTE_W;
    localparam int unsigned TOP_L = 2 * BYTE_W;

    // Load pointer slices or advance after a data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            unique case (sel)
                SEL_DATA: ptr <= ptr + PTR_W'(1);
                SEL_PLO:  ptr[BYTE_W-1:0] <= wdata;
                SEL_PMID: ptr[MID_L +: BYTE_W] <= wdata;
                SEL_PHI:  ptr[TOP_L +: TOP_W] <= wdata[TOP_W-1:0];
                default:  ptr <= ptr;
            endcase
        end
    end

endmodule

// File: rtl/wram_port_wr.sv
// RAM write issue stage for the fill port.
// Registers one RAM write per data-port write, using the pointer value
// from before that write's increment. Address and data hold between writes.
module wram_port_wr
    import wram_port_pkg::*;
#(
    parameter int unsigned PTR_W  = 17,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);

    // Strobe the RAM enable for one cycle per data write
    always_ff @(posedge clk) begin
        if (!rst_n) ram_we <= 1'b0;
        else        ram_we <= (sel == SEL_DATA);
    end

    // Capture the address and data for the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else if (sel == SEL_DATA) begin
            ram_addr  <= ptr;
            ram_wdata <= wdata;
        end
    end

endmodule

// File: rtl/wram_fill_port.sv
// Auto-incrementing work-RAM fill port (top level).
// Decodes four register slots in the low 16 bus address bits, keeps a
// byte-loadable RAM pointer, and issues one registered RAM write per
// data-port write. Assumes a synchronous RAM that writes on ram_we.
module wram_fill_port
    import wram_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 17,
    parameter int unsigned DEC_W  = 16,
    parameter logic [DEC_W-1:0] BASE = 16'h2180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_data,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);

    reg_sel_e         sel;
    logic [PTR_W-1:0] ptr_q;

    wram_port_decode #(
        .ADDR_W (ADDR_W),
        .DEC_W  (DEC_W),
        .BASE   (BASE)
    ) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .sel      (sel)
    );

    wram_port_ptr #(
        .PTR_W  (PTR_W),
        .BYTE_W (BYTE_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wdata (bus_data),
        .ptr   (ptr_q)
    );

    wram_port_wr #(
        .PTR_W  (PTR_W),
        .BYTE_W (BYTE_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .ptr       (ptr_q),
        .wdata     (bus_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

endmodule

// File: rtl/wram_port_chk.sv
// Assertion checker for the fill port, bound to the top module.
// Observes the bus inputs, RAM outputs and the internal pointer.
module wram_port_chk #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_data,
    input logic              ram_we,
    input logic [PTR_W-1:0]  ram_addr,
    input logic [BYTE_W-1:0] ram_wdata,
    input logic [PTR_W-1:0]  ptr_q
);

    logic hit_data, hit_lo, hit_mid, hit_hi;
    assign hit_data = bus_wr && (bus_addr[15:0] == 16'h2180);
    assign hit_lo   = bus_wr && (bus_addr[15:0] == 16'h2181);
    assign hit_mid  = bus_wr && (bus_addr[15:0] == 16'h2182);
    assign hit_hi   = bus_wr && (bus_addr[15:0] == 16'h2183);

    p_write_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_data |=> (ram_we && ram_addr == $past(ptr_q) && ram_wdata == $past(bus_data)));

    p_ptr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_data |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

    p_low_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> (ptr_q[7:0] == $past(bus_data) && ptr_q[16:8] == $past(ptr_q[16:8])));

    p_mid_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mid |=> (ptr_q[15:8] == $past(bus_data)
                     && ptr_q[16] == $past(ptr_q[16]) && ptr_q[7:0] == $past(ptr_q[7:0])));

    p_top_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> (ptr_q[16] == $past(bus_data[0]) && ptr_q[15:0] == $past(ptr_q[15:0])));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && ptr_q == '1) |=> (ptr_q == '0));

    p_we_only_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_data |=> !ram_we);

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_data || hit_lo || hit_mid || hit_hi) |=> $stable(ptr_q));

endmodule

bind wram_fill_port wram_port_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ptr_q     (ptr_q)
);

// File: tb/test_wram_fill_port.sv
// Self-checking bench: directed pointer corners plus seeded random traffic.
module test_wram_fill_port;

    localparam int unsigned SEED   = 32'h5EED_1234;
    localparam int unsigned N_RAND = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        ram_we;
    logic [16:0] ram_addr;
    logic [7:0]  ram_wdata;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [16:0] ptr_m    = '0;
    logic [7:0]  mem [int];
    logic [7:0]  mem_m [int];

    always #10 clk = ~clk;

    wram_fill_port i_wram_fill_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    // RAM model: captures every write the block issues
    always @(posedge clk) begin
        if (ram_we) mem[int'(ram_addr)] = ram_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] next_ptr(input logic [16:0] p,
                                             input logic [23:0] a, input logic [7:0] d);
        case (a[15:0])
            16'h2180: return p + 17'd1;
            16'h2181: return {p[16:8], d};
            16'h2182: return {p[16], d, p[7:0]};
            16'h2183: return {d[0], p[15:0]};
            default:  return p;
        endcase
    endfunction

    // One bus write; checks the RAM outputs after the capturing edge
    task automatic bus_write(input logic [23:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_data = d;
        @(posedge clk); #1;
        if (a[15:0] == 16'h2180) begin
            check(ram_we === 1'b1, req, "ram_we", 32'(ram_we), 32'd1);
            check(ram_addr === ptr_m, req, "ram_addr", 32'(ram_addr), 32'(ptr_m));
            check(ram_wdata === d, req, "ram_wdata", 32'(ram_wdata), 32'(d));
            mem_m[int'(ptr_m)] = d;
        end else begin
            check(ram_we === 1'b0, "R9", "ram_we on non-data", 32'(ram_we), 32'd0);
        end
        ptr_m = next_ptr(ptr_m, a, d);
        @(negedge clk);
        bus_wr = 1'b0;
        @(posedge clk); #1;
        check(ram_we === 1'b0, "R2", "ram_we single cycle", 32'(ram_we), 32'd0);
    endtask

    task automatic set_ptr(input logic [16:0] p, input logic [7:0] bank, input string req);
        bus_write({bank, 16'h2181}, p[7:0], req);
        bus_write({bank, 16'h2182}, p[15:8], req);
        bus_write({bank, 16'h2183}, {7'h55, p[16]}, req);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(SEED);
        repeat (3) @(posedge clk);
        #1;
        check(ram_we === 1'b0, "R1", "ram_we in reset", 32'(ram_we), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(ram_we === 1'b0, "R1", "ram_we after reset", 32'(ram_we), 32'd0);

        // R1: first data write lands at address 0
        bus_write(24'h002180, 8'hA5, "R1");
        // R3: consecutive data writes
        bus_write(24'h002180, 8'h11, "R3");
        bus_write(24'h002180, 8'h22, "R3");
        // R4/R5/R6: byte loads, top slot with noisy upper bits
        bus_write(24'h002181, 8'h34, "R4");
        bus_write(24'h002182, 8'h12, "R5");
        bus_write(24'h002183, 8'hFE, "R6");
        bus_write(24'h002180, 8'h01, "R6");
        bus_write(24'h002183, 8'h01, "R6");
        bus_write(24'h002181, 8'h00, "R4");
        bus_write(24'h002180, 8'h02, "R5");
        // R7: wrap from the last address
        set_ptr(17'h1FFFF, 8'h00, "R7");
        bus_write(24'h002180, 8'hC3, "R7");
        bus_write(24'h002180, 8'h3C, "R7");
        // R8: other banks hit the same slots
        set_ptr(17'h0ABCD, 8'h7E, "R8");
        bus_write(24'hFF2180, 8'h77, "R8");
        // R9: neighbours of the slot range and idle strobe
        bus_write(24'h00217F, 8'hFF, "R9");
        bus_write(24'h002184, 8'hFF, "R9");
        bus_write(24'h003181, 8'hFF, "R9");
        bus_write(24'h002180, 8'h88, "R9");

        // Seeded random mix
        for (int i = 0; i < N_RAND; i++) begin
            int unsigned k;
            logic [23:0] a;
            k = $urandom % 7;
            a[23:16] = 8'($urandom);
            if (k < 4)      a[15:0] = 16'h2180 + 16'(k);
            else if (k < 6) a[15:0] = 16'h2180;
            else begin
                a[15:0] = 16'($urandom);
                if (a[15:2] == 14'h0860) a[12] = ~a[12];
            end
            bus_write(a, 8'($urandom), "R3");
        end

        // RAM model contents against the expected byte map
        foreach (mem_m[key]) begin
            check(mem.exists(key) && mem[key] === mem_m[key], "R2", "ram content",
                  mem.exists(key) ? 32'(mem[key]) : 32'hFFFF_FFFF, 32'(mem_m[key]));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule